// File: doc/BRIEF.md
# Interrupt Source Router

This block steers a set of interrupt request lines onto the request inputs of a cascaded priority controller. It has thirty-four sources: fifteen come from device pins (eleven general-purpose lines and four shareable PCI-style lines) and nineteen come from on-chip peripherals. Each source carries its own programmable destination. The destination picks one of twenty-two priority channels, the non-maskable interrupt output, or nothing. More than one source may share a channel, and the shared requests are ORed together.

Pin sources can have their sense flipped before routing, so an active-low line can drive an active-high channel. Peripheral sources are always routed as they arrive. Software can also raise any channel, or the non-maskable output, without a hardware request. The non-maskable output is qualified by a global enable. The request path from source to channel is purely combinational. Configuration is held in flops and loaded through a simple write port. A write takes effect at the rising clock edge that captures it.

Top module: `irq_source_router`

## Requirements
- R1: After reset every destination is disabled, no inversion is set, no software request is set and the NMI enable is off, so both outputs stay low whatever the request inputs do.
- R2: Source index s is `extReq[s]` for s in 0..14 and `intReq[s-15]` for s in 15..33. Writing address s (0..33) loads `cfgData[4:0]` as that source's destination code. A code k in 1..22 makes the active source drive `chanOut[k-1]`.
- R3: Destination codes 0 and 24..31 disable the source, so it drives neither output.
- R4: When several active sources share a destination code, the output is high while at least one of them is active.
- R5: Code 23 routes a source to the NMI. Writing address 36 loads the NMI enable from `cfgData[0]`. `nmiOut` is high only when the enable is set and either a source routed to NMI is active or the NMI software request is set.
- R6: Writing address 34 loads the inversion mask from `cfgData[14:0]`. Bit i inverts `extReq[i]` before routing. Peripheral requests are never inverted.
- R7: Writing address 35 loads the software request bits. `cfgData[21:0]` force `chanOut[21:0]` high, and `cfgData[22]` is the NMI software request.
- R8: A change on a request input reaches the outputs in the same cycle, with no clock edge needed.
- R9: A configuration write changes the outputs only after the rising clock edge that samples `cfgWe` high. Before that edge the outputs still follow the old settings.
- R10: Writes to addresses 37..63 change no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration flops |
| rstN | input | 1 | Asynchronous active-low reset |
| extReq | input | 15 | Pin request lines (sources 0..14) |
| intReq | input | 19 | Peripheral request lines (sources 15..33) |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 6 | Configuration register select |
| cfgData | input | 23 | Configuration write data |
| chanOut | output | 22 | Requests to the priority channels |
| nmiOut | output | 1 | Non-maskable interrupt request |

## Verification
A sweep maps each of the thirty-four sources to a channel and raises one source at a time. This exposes any swapped source index, any code-to-channel offset error, and any mix-up at the boundary between pin and peripheral sources. Other patterns activate two sources that share a channel, one at a time and then together, to separate OR-combining from last-writer behaviour. Flipping the inversion mask with pin and peripheral requests held low shows that only pin sources can be inverted. The remaining patterns cover the NMI code with the enable off and then on, codes above 23, writes to unused addresses, and an output sample taken just before the capturing edge, which shows whether a write leaks through early.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NUM_EXT   = 15;
  localparam int NUM_INT   = 19;
  localparam int NUM_SRC   = NUM_EXT + NUM_INT;
  localparam int NUM_CHAN  = 22;
  localparam int DEST_W    = 5;
  localparam int NMI_CODE  = NUM_CHAN + 1;
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = NUM_CHAN + 1;
  localparam int ADDR_POL  = NUM_SRC;
  localparam int ADDR_SW   = NUM_SRC + 1;
  localparam int ADDR_NMIE = NUM_SRC + 2;

  typedef struct packed {
    logic              destWe;
    logic              polWe;
    logic              swWe;
    logic              nmiEnWe;
    logic [ADDR_W-1:0] srcIdx;
    logic [DATA_W-1:0] data;
  } cfg_strobe_t;
endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  output cfg_strobe_t       stb
);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(ADDR_POL);
  localparam logic [ADDR_W-1:0] A_SW   = ADDR_W'(ADDR_SW);
  localparam logic [ADDR_W-1:0] A_NMIE = ADDR_W'(ADDR_NMIE);

  always_comb begin
    stb = '0;
    stb.srcIdx = cfgAddr;
    stb.data = cfgData;
    if (cfgWe) begin
      if (cfgAddr < A_POL)        stb.destWe  = 1'b1;
      else if (cfgAddr == A_POL)  stb.polWe   = 1'b1;
      else if (cfgAddr == A_SW)   stb.swWe    = 1'b1;
      else if (cfgAddr == A_NMIE) stb.nmiEnWe = 1'b1;
    end
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.destWe, stb.polWe, stb.swWe, stb.nmiEnWe}));

  // R10
  unused_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr > A_NMIE) |-> !(stb.destWe || stb.polWe || stb.swWe || stb.nmiEnWe));
endmodule

// File: rtl/irq_router_xbar.sv
module irq_router_xbar
  import irq_router_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_SRC-1:0]                srcVal,
  input  logic [NUM_SRC-1:0][DEST_W-1:0]    destVec,
  output logic [NUM_CHAN-1:0]               chanHit,
  output logic                              nmiHit
);
  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (srcVal[s] && (destVec[s] == DEST_W'(c + 1))) hit = 1'b1;
      end
    end
    assign chanHit[c] = hit;
  end

  always_comb begin
    nmiHit = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (srcVal[s] && (destVec[s] == DEST_W'(NMI_CODE))) nmiHit = 1'b1;
    end
  end

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcVal == '0) |-> (chanHit == '0 && !nmiHit));
endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  cfg_strobe_t         stb,
  input  logic [NUM_EXT-1:0]  extReq,
  input  logic [NUM_INT-1:0]  intReq,
  output logic [NUM_CHAN-1:0] chanOut,
  output logic                nmiOut
);
  logic [NUM_SRC-1:0][DEST_W-1:0] destReg;
  logic [NUM_EXT-1:0]             invReg;
  logic [NUM_CHAN:0]              swReg;
  logic                           nmiEn;
  logic [NUM_SRC-1:0]             srcVal;
  logic [NUM_CHAN-1:0]            chanHit;
  logic                           nmiHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      destReg <= '0;
      invReg  <= '0;
      swReg   <= '0;
      nmiEn   <= 1'b0;
    end else begin
      if (stb.destWe)  destReg[stb.srcIdx] <= stb.data[DEST_W-1:0];
      if (stb.polWe)   invReg <= stb.data[NUM_EXT-1:0];
      if (stb.swWe)    swReg  <= stb.data[NUM_CHAN:0];
      if (stb.nmiEnWe) nmiEn  <= stb.data[0];
    end
  end

  assign srcVal = {intReq, extReq ^ invReg};

  irq_router_xbar xbar_i (
    .clk     (clk),
    .rstN    (rstN),
    .srcVal  (srcVal),
    .destVec (destReg),
    .chanHit (chanHit),
    .nmiHit  (nmiHit)
  );

  assign chanOut = chanHit | swReg[NUM_CHAN-1:0];
  assign nmiOut  = nmiEn & (nmiHit | swReg[NUM_CHAN]);

  // R9
  sw_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.swWe |=> (swReg == $past(stb.data[NUM_CHAN:0])));

  // R6
  pol_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.polWe |=> (invReg == $past(stb.data[NUM_EXT-1:0])));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.destWe || stb.polWe || stb.swWe || stb.nmiEnWe) |=>
      ($stable(destReg) && $stable(invReg) && $stable(swReg) && $stable(nmiEn)));

  // R5
  nmi_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !nmiEn |-> !nmiOut);
endmodule

// File: rtl/irq_source_router.sv
module irq_source_router
  import irq_router_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_EXT-1:0]  extReq,
  input  logic [NUM_INT-1:0]  intReq,
  input  logic                cfgWe,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [DATA_W-1:0]   cfgData,
  output logic [NUM_CHAN-1:0] chanOut,
  output logic                nmiOut
);
  cfg_strobe_t stb;

  irq_router_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgAddr (cfgAddr),
    .cfgData (cfgData),
    .stb     (stb)
  );

  irq_router_dp dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .extReq  (extReq),
    .intReq  (intReq),
    .chanOut (chanOut),
    .nmiOut  (nmiOut)
  );
endmodule

// File: tb/irq_source_router_tb.sv
module irq_source_router_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] extReq = '0;
  logic [18:0] intReq = '0;
  logic        cfgWe = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic [22:0] cfgData = '0;
  logic [21:0] chanOut;
  logic        nmiOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [4:0]  mDest [34];
  logic [14:0] mInv = '0;
  logic [22:0] mSw = '0;
  logic        mNmiEn = 1'b0;

  always #4 clk = ~clk;

  irq_source_router dut_i (
    .clk(clk), .rstN(rstN), .extReq(extReq), .intReq(intReq),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .chanOut(chanOut), .nmiOut(nmiOut)
  );

  function automatic logic [22:0] model(input logic [14:0] e, input logic [18:0] i);
    logic [21:0] ch = '0;
    logic n = 1'b0;
    for (int s = 0; s < 34; s++) begin
      logic v = (s < 15) ? (e[s] ^ mInv[s]) : i[s-15];
      int d = int'(mDest[s]);
      if (v && d >= 1 && d <= 22) ch[d-1] = 1'b1;
      if (v && d == 23) n = 1'b1;
    end
    ch = ch | mSw[21:0];
    n = (n | mSw[22]) & mNmiEn;
    return {n, ch};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chkOut(input string tag);
    chk(tag, {9'd0, nmiOut, chanOut}, {9'd0, model(extReq, intReq)});
  endtask

  task automatic cfgWrite(input logic [5:0] a, input logic [22:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
    if (a < 34) mDest[a] = d[4:0];
    else if (a == 34) mInv = d[14:0];
    else if (a == 35) mSw = d;
    else if (a == 36) mNmiEn = d[0];
  endtask

  task automatic setReq(input logic [14:0] e, input logic [18:0] i);
    @(negedge clk);
    extReq = e; intReq = i;
    #1;
  endtask

  task automatic clearAll();
    for (int s = 0; s < 34; s++) cfgWrite(6'(s), 23'd0);
    cfgWrite(6'd34, 23'd0);
    cfgWrite(6'd35, 23'd0);
    cfgWrite(6'd36, 23'd0);
  endtask

  task automatic testReset();
    // R1: requests all high during and after reset, outputs must stay low
    extReq = '1; intReq = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset chanOut", {10'd0, chanOut}, 32'd0);
    chk("R1 reset nmiOut", {31'd0, nmiOut}, 32'd0);
    setReq('0, '0);
  endtask

  task automatic testSweep();
    // R2: each source to its own channel, one source active at a time
    for (int s = 0; s < 34; s++) cfgWrite(6'(s), 23'((s % 22) + 1));
    for (int s = 0; s < 34; s++) begin
      logic [33:0] one = 34'd1 << s;
      setReq(one[14:0], one[33:15]);
      chk("R2 single source route", {10'd0, chanOut}, 32'd1 << (s % 22));
    end
    setReq('0, '0);
    clearAll();
  endtask

  task automatic testShare();
    // R4: sources 3 and 20 share code 5
    cfgWrite(6'd3, 23'd5);
    cfgWrite(6'd20, 23'd5);
    setReq(15'h0008, '0);
    chkOut("R4 share first only");
    setReq('0, 19'h00020);
    chkOut("R4 share second only");
    setReq(15'h0008, 19'h00020);
    chkOut("R4 share both");
    chk("R4 share both bit", {31'd0, chanOut[4]}, 32'd1);
    setReq('0, '0);
    chkOut("R4 share none");
    clearAll();
  endtask

  task automatic testNmi();
    // R5: code 23 to NMI, gated by enable at address 36
    cfgWrite(6'd7, 23'd23);
    setReq(15'h0080, '0);
    chk("R5 nmi disabled", {31'd0, nmiOut}, 32'd0);
    cfgWrite(6'd36, 23'd1);
    chk("R5 nmi enabled", {31'd0, nmiOut}, 32'd1);
    chk("R5 nmi no channel", {10'd0, chanOut}, 32'd0);
    setReq('0, '0);
    chk("R5 nmi source idle", {31'd0, nmiOut}, 32'd1 & 32'(model(extReq, intReq) >> 22));
    clearAll();
  endtask

  task automatic testPolarity();
    // R6: invert ext pin 2 and try to invert everything; internal never inverts
    cfgWrite(6'd2, 23'd9);
    cfgWrite(6'd30, 23'd10);
    setReq('0, '0);
    chkOut("R6 before invert");
    cfgWrite(6'd34, 23'h7FFFFF);
    chkOut("R6 inverted ext low");
    chk("R6 ext ch9 high", {31'd0, chanOut[8]}, 32'd1);
    chk("R6 int not inverted", {31'd0, chanOut[9]}, 32'd0);
    setReq(15'h0004, '0);
    chk("R6 inverted ext high", {31'd0, chanOut[8]}, 32'd0);
    setReq('0, '0);
    clearAll();
  endtask

  task automatic testSoftware();
    // R7: force channels 0, 13, 21 and the NMI request
    cfgWrite(6'd35, 23'h602001);
    chkOut("R7 sw channels nmi off");
    chk("R7 sw nmi gated", {31'd0, nmiOut}, 32'd0);
    cfgWrite(6'd36, 23'd1);
    chk("R7 sw nmi", {31'd0, nmiOut}, 32'd1);
    chk("R7 sw chan", {10'd0, chanOut}, 32'h202001);
    clearAll();
  endtask

  task automatic testDisabledCodes();
    // R3: codes 0 and 24..31 drive nothing
    cfgWrite(6'd36, 23'd1);
    for (int code = 24; code < 32; code++) begin
      cfgWrite(6'd11, 23'(code));
      setReq(15'h0800, '0);
      chk("R3 high code disabled", {9'd0, nmiOut, chanOut}, 32'd0);
      setReq('0, '0);
    end
    cfgWrite(6'd11, 23'd0);
    setReq(15'h0800, 19'h7FFFF);
    chk("R3 code zero disabled", {9'd0, nmiOut, chanOut}, 32'd0);
    setReq('0, '0);
    clearAll();
  endtask

  task automatic testTiming();
    // R8 and R9
    cfgWrite(6'd0, 23'd4);
    @(negedge clk);
    extReq = 15'h0001;
    #1;
    chk("R8 comb path", {10'd0, chanOut}, 32'h8);
    extReq = '0;
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 6'd35; cfgData = 23'h000040;
    @(posedge clk);
    #0;
    chk("R9 before edge", {10'd0, chanOut}, 32'd0);
    #1;
    chk("R9 after edge", {10'd0, chanOut}, 32'h40);
    @(negedge clk);
    cfgWe = 1'b0;
    mSw = 23'h000040;
    clearAll();
  endtask

  task automatic testUnused();
    // R10: writes to 37 and 63 change nothing
    cfgWrite(6'd37, 23'h7FFFE1);
    cfgWrite(6'd50, 23'h7FFFE1);
    cfgWrite(6'd63, 23'h7FFFE1);
    setReq('1, '1);
    chk("R10 unused addr", {9'd0, nmiOut, chanOut}, 32'd0);
    setReq('0, '0);
  endtask

  initial begin
    for (int s = 0; s < 34; s++) mDest[s] = '0;
    testReset();
    testSweep();
    testShare();
    testNmi();
    testPolarity();
    testSoftware();
    testDisabledCodes();
    testTiming();
    testUnused();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule